// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a small 8-bit controller. It watches the controller's register write port (strobe, address, data). Software turns it on by writing two fixed key bytes, one after the other, to the watchdog address. It keeps the watchdog quiet by writing the same two bytes again before the count runs out. While enabled, a 13-bit counter advances on each machine-cycle enable pulse. When the counter reaches its maximum value, the block drives a reset pulse of fixed length, counted in oscillator clocks.

Low-power state can suspend counting. Power-down always freezes the counter. When power-down is left, the counter stays frozen for as long as the wake interrupt line is held low. A bit in an auxiliary register selects whether counting continues in idle. Software cannot read or load the counter. Only the key sequence clears it.

Top module: `keyed_watchdog`

## Requirements
- R1: After the asynchronous active-low reset, `wdt_rst_o` is 0, the watchdog is disabled, the counter is zero, no key byte is pending and the idle-stop bit is 0. A reset also disables a watchdog that was enabled.
- R2: A write of 0x1E to address 0xA6, followed later by a write of 0xE1 to address 0xA6, enables the watchdog. Until that happens, ticks do not advance the counter and no reset pulse appears. A lone 0xE1 does nothing.
- R3: After a 0x1E write, any write of a value other than 0xE1 to 0xA6 abandons the sequence. A further 0x1E write starts it again. Writes to other addresses between the two key bytes do not disturb it.
- R4: When the watchdog is enabled, the completed key sequence clears the counter to zero. This pushes the next reset pulse back by the full count.
- R5: While enabled and not suspended, the counter rises by exactly one on each cycle where `mc_tick_i` is 1. On the clock edge after the count becomes 0x1FFF, `wdt_rst_o` goes to 1. With a tick on every cycle, this is 8192 cycles after the cycle of the 0xE1 write.
- R6: `wdt_rst_o` stays high for exactly 98 clock cycles.
- R7: Software cannot disable the watchdog.
  - While the pulse is high, the counter and the key logic are held cleared, and key writes are ignored.
  - After the pulse, the watchdog is disabled until the key sequence is written again.
- R8: While `pdown_i` is 1, the counter does not advance.
- R9: After `pdown_i` falls, the counter stays frozen while `wake_irq_n_i` is 0. Counting resumes in the first cycle where the line is 1.
- R10: Bit 4 of a write to address 0x8E sets the idle-stop bit.
  - With the bit at 0, the counter keeps advancing while `idle_i` is 1.
  - With the bit at 1, the counter pauses while `idle_i` is 1 and resumes when idle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick_i | input | 1 | Machine-cycle enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| idle_i | input | 1 | Controller is in idle |
| pdown_i | input | 1 | Controller is in power-down |
| wake_irq_n_i | input | 1 | Level wake interrupt line, active low |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench goes after the cycle in which the pulse starts. A counter that is off by one, or that detects overflow one register late, would move the rising edge by a cycle, and the every-clock comparison would flag it.

It also targets:
- **Broken sequences and writes during the pulse.** A key detector that kept a stale first byte, or that accepted keys during the pulse, would enable the watchdog when it should not. That would produce an extra pulse in a window that should stay silent.
- **Power-down exit with the wake line still low.** If the wake hold were dropped, counting would restart early.
- **Idle with both settings of the idle-stop bit.** Mixing up the bit's polarity or position would either fire a pulse during a paused idle or fail to fire one during counting idle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  // Progress through the two-byte key
  typedef enum logic {
    KS_WAIT = 1'b0,
    KS_HALF = 1'b1
  } key_state_e;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hit_o
);
  key_state_e state_q, state_d;
  logic key_wr;

  assign key_wr = wr_en_i && (wr_addr_i == KEY_ADDR);
  assign hit_o  = key_wr && !wipe_i && (state_q == KS_HALF) && (wr_data_i == KEY_B);

  always_comb begin
    state_d = state_q;
    if (wipe_i) begin
      state_d = KS_WAIT;
    end else if (key_wr) begin
      state_d = (wr_data_i == KEY_A) ? KS_HALF : KS_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_WAIT;
    else        state_q <= state_d;
  end

  // R7
  key_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> (state_q == KS_WAIT));

  // R3
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe_i && !key_wr) |=> $stable(state_q));
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int CNT_W = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hit_i,
  input  logic wipe_i,
  input  logic pdown_i,
  input  logic wake_n_i,
  input  logic idle_i,
  input  logic idle_stop_i,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             en_q, en_d;
  logic             hold_q, hold_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             freeze, pause, step;

  assign freeze = pdown_i || (hold_q && !wake_n_i);
  assign pause  = idle_i && idle_stop_i;
  assign step   = en_q && tick_i && !freeze && !pause;
  assign ovf_o  = en_q && (cnt_q == CNT_MAX);

  always_comb begin
    en_d   = en_q;
    cnt_d  = cnt_q;
    hold_d = pdown_i || (hold_q && !wake_n_i);
    if (wipe_i) begin
      en_d  = 1'b0;
      cnt_d = '0;
    end else if (hit_i) begin
      en_d  = 1'b1;
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe_i && !hit_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE));

  // R7
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(wipe_i));

  // R8
  pdown_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown_i && !wipe_i && !hit_i) |=> $stable(cnt_q));

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wake_n_i && !wipe_i && !hit_i) |=> $stable(cnt_q));

  // R10
  idle_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && idle_stop_i && !wipe_i && !hit_i) |=> $stable(cnt_q));
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_LEN = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  output logic pulse_o
);
  localparam int LEN_W = $clog2(PULSE_LEN + 1);
  localparam logic [LEN_W-1:0] LAST = LEN_W'(PULSE_LEN - 1);

  logic             busy_q, busy_d;
  logic [LEN_W-1:0] left_q, left_d;

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    if (ovf_i && !busy_q) begin
      busy_d = 1'b1;
      left_d = LAST;
    end else if (busy_q) begin
      if (left_q == '0) busy_d = 1'b0;
      else              left_d = left_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      left_q <= left_d;
    end
  end

  assign pulse_o = busy_q;

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(ovf_i));

  // R6
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && left_q != '0) |=> busy_q);

  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(left_q) == '0));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W = 13,
  parameter int PULSE_LEN = 98,
  parameter int IDLE_BIT = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 8'h8E,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              wake_irq_n_i,
  output logic              wdt_rst_o
);
  logic hit, ovf, busy, wipe;
  logic idle_stop_q, idle_stop_d;

  assign wipe = busy || ovf;

  always_comb begin
    idle_stop_d = idle_stop_q;
    if (wr_en_i && (wr_addr_i == AUX_ADDR)) idle_stop_d = wr_data_i[IDLE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_stop_q <= 1'b0;
    else        idle_stop_q <= idle_stop_d;
  end

  kwdt_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KEY_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .wipe_i(wipe),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .hit_o(hit)
  );

  kwdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(mc_tick_i), .hit_i(hit), .wipe_i(wipe),
    .pdown_i(pdown_i), .wake_n_i(wake_irq_n_i), .idle_i(idle_i),
    .idle_stop_i(idle_stop_q), .ovf_o(ovf)
  );

  kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .pulse_o(busy)
  );

  assign wdt_rst_o = busy;

  // R1
  quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(ovf));
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] data = 8'h00;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       wake_n = 1'b1;
  logic       rst_o;

  int    checks = 0, fails = 0, cycles = 0;
  int    tick_per = 1, tick_ph = 0;
  int    pulses = 0, hi_run = 0;
  string cur_req = "R1";

  // Reference model state
  bit m_arm, m_en, m_busy, m_hold, m_idle;
  int m_cnt, m_left;
  bit ovf, keyw, hit, frz;

  always #2.5 clk = ~clk;

  keyed_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .mc_tick_i(tick), .wr_en_i(wr),
    .wr_addr_i(addr), .wr_data_i(data), .idle_i(idle), .pdown_i(pdown),
    .wake_irq_n_i(wake_n), .wdt_rst_o(rst_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, got, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arm = 0; m_en = 0; m_cnt = 0; m_busy = 0; m_left = 0; m_hold = 0; m_idle = 0;
    end else begin
      ovf  = m_en && (m_cnt == 8191);
      keyw = wr && (addr == 8'hA6);
      hit  = keyw && (data == 8'hE1) && m_arm;
      frz  = pdown || (m_hold && !wake_n);
      if (m_busy || ovf) begin
        m_arm = 0; m_en = 0; m_cnt = 0;
      end else begin
        if (hit) begin m_en = 1; m_cnt = 0; end
        else if (m_en && tick && !frz && !(idle && m_idle)) m_cnt++;
        if (keyw) m_arm = (data == 8'h1E);
      end
      m_hold = pdown || (m_hold && !wake_n);
      if (wr && addr == 8'h8E) m_idle = data[4];
      if (ovf) begin m_busy = 1; m_left = 97; end
      else if (m_busy) begin
        if (m_left == 0) m_busy = 0;
        else m_left--;
      end
    end
  end

  // Every-clock comparison and pulse-width tracking
  always @(negedge clk) begin
    chk(cur_req, int'(rst_o), int'(m_busy));
    if (rst_o) hi_run++;
    else if (hi_run != 0) begin
      pulses++;
      chk("R6", hi_run, 98);
      hi_run = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input logic w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = w; addr = a; data = d;
    tick = (tick_ph == 0);
    tick_ph = (tick_ph + 1) % tick_per;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 8'h00);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b1, a, d);
    cyc(1'b0, 8'h00, 8'h00);
  endtask

  task automatic key();
    wreg(8'hA6, 8'h1E);
    wreg(8'hA6, 8'hE1);
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 30000 && !rst_o; i++) cyc(1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", int'(rst_o), 0);
    rst_n = 1'b1;
    run(20);
    chk("R1", int'(rst_o), 0);

    // R2: no counting while disabled, lone second byte ignored
    cur_req = "R2";
    run(300);
    wreg(8'hA6, 8'hE1);
    run(9000);
    chk("R2", pulses, 0);

    // R2 / R5 / R6: enable and let it overflow
    cur_req = "R5";
    key();
    wait_pulse();
    chk("R5", int'(rst_o), 1);

    // R7: keys during the pulse are ignored, and the watchdog is disabled afterwards
    cur_req = "R7";
    key();
    run(9000);
    chk("R7", pulses, 1);

    // R3: broken sequence, then one with a foreign write in between
    cur_req = "R3";
    wreg(8'hA6, 8'h1E);
    wreg(8'hA6, 8'h55);
    wreg(8'hA6, 8'hE1);
    run(9000);
    chk("R3", pulses, 1);
    wreg(8'hA6, 8'h1E);
    wreg(8'h80, 8'h00);
    wreg(8'hA6, 8'hE1);

    // R4: service part way through
    cur_req = "R4";
    run(5000);
    key();
    run(6000);
    chk("R4", pulses, 1);
    wait_pulse();
    run(200);
    chk("R4", pulses, 2);

    // R8 / R9: power-down, then a held wake line, with slower ticks
    cur_req = "R8";
    tick_per = 3;
    key();
    run(4000);
    pdown = 1'b1;
    run(3000);
    cur_req = "R9";
    wake_n = 1'b0;
    run(5);
    pdown = 1'b0;
    run(2000);
    chk("R9", pulses, 2);
    wake_n = 1'b1;
    run(23000);
    chk("R8", pulses, 3);
    tick_per = 1;

    // R10: idle with the stop bit clear, then set
    cur_req = "R10";
    wreg(8'h8E, 8'h00);
    key();
    idle = 1'b1;
    run(8400);
    chk("R10", pulses, 4);
    idle = 1'b0;
    wreg(8'h8E, 8'h10);
    key();
    idle = 1'b1;
    run(9000);
    chk("R10", pulses, 4);
    idle = 1'b0;
    run(8400);
    chk("R10", pulses, 5);

    // R1: a reset disables an enabled watchdog
    cur_req = "R1";
    key();
    run(100);
    @(negedge clk);
    #1 rst_n = 1'b0;
    run(3);
    chk("R1", int'(rst_o), 0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    run(9000);
    chk("R1", pulses, 5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule